// File: doc/BRIEF.md
# Bitmap Font Text Row Renderer

This block turns a short line of ASCII text into pixels for a small colour display. A line holds up to 19 character slots. Each character is drawn from a 5-pixel-wide, 8-pixel-tall monospaced font. The block latches the characters, a count of how many slots are in use, and a 16-bit foreground colour. It then emits the whole 8-pixel-tall band as 16-bit pixels on a valid/ready stream.

The order is raster order. All 95 pixels of glyph row 0 come first, running across every slot, then glyph row 1, and so on down to row 7. A set font bit becomes the foreground colour and a clear bit becomes black.

The font table is loaded through a write port, one glyph row at a time. Each glyph row is a single long bit string that holds that row of every printable glyph side by side, so no per-character words are stored. A glyph is found by its bit offset inside the selected row string. Slots beyond the count, and codes that are not printable, are drawn with the space glyph.

Top module: `txt_row_render`

## Requirements
- R1: After reset `busy` and `pix_valid` are low.
- R2: A `start` pulse seen at a clock edge while `busy` is low is accepted. `busy` is high after that edge, and the first pixel is valid after the following edge.
- R3: One accepted line produces exactly 8 × 95 = 760 pixel transfers. The order is glyph row 0 to 7, and within a row slot 0 to 18, and within a slot pixel column 0 to 4. `busy` and `pix_valid` are low once the last transfer has been taken.
- R4: Character slot i is `text_chars[8i+7:8i]`. For printable code c in glyph row r, the five pixels are bits `[(c-0x20)*5+4 : (c-0x20)*5]` of font row string r, and the higher-numbered bit is the leftmost pixel.
- R5: A set font bit yields `fg_color` and a clear bit yields 16'h0000.
- R6: Slots with index at or above `text_len` are drawn with the glyph of code 0x20. A `text_len` above 19 is treated as 19, and 0 gives a line drawn entirely with the 0x20 glyph.
- R7: A code below 0x20 or above 0x7E is drawn with the glyph of code 0x20.
- R8: While `pix_valid` is high and `pix_ready` is low, `pix_valid` stays high and `pix_data` is unchanged at the next edge.
- R9: `text_chars`, `text_len` and `fg_color` are captured when `start` is accepted. A `start` while `busy`, and any change of these inputs after acceptance, do not alter the line being emitted.
- R10: When `font_we` is high at an edge, `font_bits` replaces the whole row string selected by `font_row` (0 to 7). Lines started after the write use the new content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to render a line |
| text_chars | input | 152 | 19 character codes, slot 0 in the low byte |
| text_len | input | 5 | Number of slots in use |
| fg_color | input | 16 | Colour used for set font bits |
| busy | output | 1 | A line is being produced or a pixel is still held |
| pix_valid | output | 1 | Pixel stream valid |
| pix_ready | input | 1 | Pixel stream ready |
| pix_data | output | 16 | Pixel colour |
| font_we | input | 1 | Font row write strobe |
| font_row | input | 3 | Glyph row being written |
| font_bits | input | 475 | Complete bit string of one glyph row |

## Verification
The hardest case to reach from the ports is a second `start`, carrying different text and colour, that arrives while the stream is stalled in the middle of a line. The stimulus holds such a request for several cycles under a pseudo-random ready pattern, then checks the remaining pixels against the first line. The space glyph in the test font is deliberately not blank, so that slots past the count and unprintable codes give a visible result. One test rewrites some font rows between lines, so that stale glyph data would show up in the next line.

// File: rtl/txt_pkg.sv
package txt_pkg;
    localparam int GLYPH_W    = 5;
    localparam int GLYPH_H    = 8;
    localparam int CODE_W     = 8;
    localparam int FIRST_CODE = 8'h20;
    localparam int LAST_CODE  = 8'h7E;
    localparam int NUM_GLYPHS = LAST_CODE - FIRST_CODE + 1;
    localparam int ROW_BITS   = NUM_GLYPHS * GLYPH_W;
    localparam int ROW_IDX_W  = $clog2(GLYPH_H);
    localparam int COL_IDX_W  = $clog2(GLYPH_W);
    localparam int OFF_W      = $clog2(ROW_BITS);
endpackage

// File: rtl/txt_font_store.sv
module txt_font_store #(
    parameter int ROWS  = txt_pkg::GLYPH_H,
    parameter int BITS  = txt_pkg::ROW_BITS,
    parameter int FW    = txt_pkg::GLYPH_W,
    localparam int RW   = $clog2(ROWS),
    localparam int OW   = $clog2(BITS)
) (
    input  logic            clk,
    input  logic            wr_en,
    input  logic [RW-1:0]   wr_row,
    input  logic [BITS-1:0] wr_bits,
    input  logic [RW-1:0]   rd_row,
    input  logic [OW-1:0]   rd_off,
    output logic [FW-1:0]   rd_field
);
    logic [BITS-1:0] strings_q [ROWS];
    logic [BITS-1:0] sel_row;
    logic [BITS-1:0] shifted;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            strings_q[wr_row] <= wr_bits;
        end
    end

    always_comb begin
        sel_row  = strings_q[rd_row];
        shifted  = sel_row >> rd_off;
        rd_field = shifted[FW-1:0];
    end
endmodule

// File: rtl/txt_glyph_addr.sv
module txt_glyph_addr #(
    parameter int CW    = txt_pkg::CODE_W,
    parameter int FW    = txt_pkg::GLYPH_W,
    parameter int LO    = txt_pkg::FIRST_CODE,
    parameter int HI    = txt_pkg::LAST_CODE,
    parameter int OW    = txt_pkg::OFF_W
) (
    input  logic [CW-1:0] code,
    input  logic          in_use,
    output logic [OW-1:0] bit_off
);
    logic          printable;
    logic [CW-1:0] glyph_idx;

    always_comb begin
        printable = (int'(code) >= LO) && (int'(code) <= HI);
        glyph_idx = (in_use && printable) ? CW'(int'(code) - LO) : '0;
        bit_off   = OW'(int'(glyph_idx) * FW);
    end
endmodule

// File: rtl/txt_raster_step.sv
module txt_raster_step #(
    parameter int SLOTS = 19,
    parameter int FW    = txt_pkg::GLYPH_W,
    parameter int ROWS  = txt_pkg::GLYPH_H,
    localparam int SW   = $clog2(SLOTS),
    localparam int CLW  = $clog2(FW),
    localparam int RW   = $clog2(ROWS)
) (
    input  logic [RW-1:0]  row,
    input  logic [SW-1:0]  slot,
    input  logic [CLW-1:0] col,
    output logic [RW-1:0]  row_nx,
    output logic [SW-1:0]  slot_nx,
    output logic [CLW-1:0] col_nx,
    output logic           at_end
);
    logic col_wrap, slot_wrap, row_wrap;

    always_comb begin
        col_wrap  = (int'(col)  == FW - 1);
        slot_wrap = (int'(slot) == SLOTS - 1);
        row_wrap  = (int'(row)  == ROWS - 1);
        at_end    = col_wrap && slot_wrap && row_wrap;

        col_nx  = col_wrap ? '0 : col + 1'b1;
        slot_nx = slot;
        row_nx  = row;
        if (col_wrap) begin
            slot_nx = slot_wrap ? '0 : slot + 1'b1;
            if (slot_wrap) begin
                row_nx = row_wrap ? '0 : row + 1'b1;
            end
        end
    end
endmodule

// File: rtl/txt_row_render.sv
module txt_row_render #(
    parameter int MAX_CHARS = 19,
    parameter int PIX_W     = 16,
    parameter int LEN_W     = 5,
    localparam int CW       = txt_pkg::CODE_W,
    localparam int FW       = txt_pkg::GLYPH_W,
    localparam int ROWS     = txt_pkg::GLYPH_H,
    localparam int BITS     = txt_pkg::ROW_BITS,
    localparam int OW       = txt_pkg::OFF_W,
    localparam int RW       = $clog2(ROWS),
    localparam int SW       = $clog2(MAX_CHARS),
    localparam int CLW      = $clog2(FW),
    localparam int TXT_W    = MAX_CHARS * CW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [TXT_W-1:0] text_chars,
    input  logic [LEN_W-1:0] text_len,
    input  logic [PIX_W-1:0] fg_color,
    output logic             busy,
    output logic             pix_valid,
    input  logic             pix_ready,
    output logic [PIX_W-1:0] pix_data,
    input  logic             font_we,
    input  logic [RW-1:0]    font_row,
    input  logic [BITS-1:0]  font_bits
);
    typedef struct packed {
        logic             active;
        logic             valid;
        logic [RW-1:0]    row;
        logic [SW-1:0]    slot;
        logic [CLW-1:0]   col;
        logic [LEN_W-1:0] len;
        logic [PIX_W-1:0] fg;
        logic [PIX_W-1:0] pix;
        logic [TXT_W-1:0] text;
    } st_t;

    st_t q, d;

    logic [CW-1:0]  cur_code;
    logic           cur_in_use;
    logic [OW-1:0]  cur_off;
    logic [FW-1:0]  cur_field;
    logic [RW-1:0]  row_nx;
    logic [SW-1:0]  slot_nx;
    logic [CLW-1:0] col_nx;
    logic           at_end;

    always_comb begin
        cur_code   = q.text[int'(q.slot) * CW +: CW];
        cur_in_use = int'(q.slot) < int'(q.len);
    end

    txt_glyph_addr u_addr (
        .code    (cur_code),
        .in_use  (cur_in_use),
        .bit_off (cur_off)
    );

    txt_font_store u_font (
        .clk      (clk),
        .wr_en    (font_we),
        .wr_row   (font_row),
        .wr_bits  (font_bits),
        .rd_row   (q.row),
        .rd_off   (cur_off),
        .rd_field (cur_field)
    );

    txt_raster_step #(.SLOTS(MAX_CHARS)) u_step (
        .row     (q.row),
        .slot    (q.slot),
        .col     (q.col),
        .row_nx  (row_nx),
        .slot_nx (slot_nx),
        .col_nx  (col_nx),
        .at_end  (at_end)
    );

    always_comb begin
        logic advance;
        logic lit;
        d       = q;
        advance = q.active && (!q.valid || pix_ready);
        lit     = cur_field[FW - 1 - int'(q.col)];

        if (q.valid && pix_ready) begin
            d.valid = 1'b0;
        end

        if (advance) begin
            d.valid  = 1'b1;
            d.pix    = lit ? q.fg : '0;
            d.row    = row_nx;
            d.slot   = slot_nx;
            d.col    = col_nx;
            if (at_end) begin
                d.active = 1'b0;
            end
        end

        if (!q.active && !q.valid && start) begin
            d.active = 1'b1;
            d.row    = '0;
            d.slot   = '0;
            d.col    = '0;
            d.text   = text_chars;
            d.fg     = fg_color;
            d.len    = (int'(text_len) > MAX_CHARS) ? LEN_W'(MAX_CHARS) : text_len;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy      = q.active || q.valid;
    assign pix_valid = q.valid;
    assign pix_data  = q.pix;
endmodule

// File: rtl/txt_row_render_chk.sv
module txt_row_render_chk #(
    parameter int MAX_CHARS = 19,
    parameter int PIX_W     = 16,
    parameter int SW        = 5,
    parameter int CLW       = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             pix_valid,
    input logic             pix_ready,
    input logic [PIX_W-1:0] pix_data,
    input logic [PIX_W-1:0] fg_q,
    input logic [SW-1:0]    slot_q,
    input logic [CLW-1:0]   col_q
);
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy); // R2
    AST_FIRST_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$past(busy)) |=> pix_valid); // R2
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_data))); // R8
    AST_COLOUR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> (pix_data == '0 || pix_data == fg_q)); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !pix_valid); // R3
    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (int'(slot_q) < MAX_CHARS && int'(col_q) < txt_pkg::GLYPH_W)); // R3
    AST_FG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(fg_q)); // R9
endmodule

bind txt_row_render txt_row_render_chk #(
    .MAX_CHARS (MAX_CHARS),
    .PIX_W     (PIX_W),
    .SW        (SW),
    .CLW       (CLW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .pix_valid (pix_valid),
    .pix_ready (pix_ready),
    .pix_data  (pix_data),
    .fg_q      (q.fg),
    .slot_q    (q.slot),
    .col_q     (q.col)
);

// File: tb/txt_row_render_bench.sv
module txt_row_render_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 19;
    localparam int NBIT = 475;
    localparam int LINE_PIX = 8 * NCH * 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [NCH*8-1:0] text_chars = '0;
    logic [4:0]       text_len = '0;
    logic [15:0]      fg_color = '0;
    logic             busy, pix_valid;
    logic             pix_ready = 1'b0;
    logic [15:0]      pix_data;
    logic             font_we = 1'b0;
    logic [2:0]       font_row = '0;
    logic [NBIT-1:0]  font_bits = '0;

    logic [NBIT-1:0]  font_m [8];
    logic [15:0]      exp_q [$];
    int checks = 0, fails = 0, cyc = 0, frame_pix = 0;
    int ready_mode = 0;
    logic [7:0] lfsr = 8'hA5;
    logic stall_seen = 1'b0;
    logic [15:0] stall_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txt_row_render u_txt_row_render (
        .clk(clk), .rst_n(rst_n), .start(start), .text_chars(text_chars),
        .text_len(text_len), .fg_color(fg_color), .busy(busy),
        .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
        .font_we(font_we), .font_row(font_row), .font_bits(font_bits)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: drives ready, pops the scoreboard on every transfer, watches stalls (R8)
    always @(negedge clk) begin
        logic rdy;
        if (rst_n) begin
            if (stall_seen) begin
                check(pix_valid && pix_data == stall_data, "R8 stall hold",
                      int'(pix_data), int'(stall_data));
            end
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            rdy = (ready_mode == 0) ? 1'b1 : (lfsr[0] | lfsr[2]);
            pix_ready = rdy;
            stall_seen = pix_valid && !rdy;
            stall_data = pix_data;
            if (pix_valid && rdy) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 extra pixel", int'(pix_data), 0);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    frame_pix++;
                    check(pix_data === e, "R4 R5 R6 R7 pixel", int'(pix_data), int'(e));
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    function automatic logic [4:0] gen_field(int idx, int r, int salt);
        return 5'((idx * 7 + r * 13 + salt) ^ (idx >> 2) ^ (r * idx));
    endfunction

    task automatic load_row(input int r, input int salt);
        logic [NBIT-1:0] v;
        v = '0;
        for (int g = 0; g < 95; g++) v[g*5 +: 5] = gen_field(g, r, salt);
        font_m[r] = v;
        @(negedge clk);
        font_we = 1'b1; font_row = 3'(r); font_bits = v;
        @(negedge clk);
        font_we = 1'b0;
    endtask

    function automatic logic [NCH*8-1:0] pack_text(string s);
        logic [NCH*8-1:0] t;
        t = '0;
        for (int i = 0; i < s.len() && i < NCH; i++) t[i*8 +: 8] = s[i];
        return t;
    endfunction

    task automatic push_expected(input logic [NCH*8-1:0] t, input int len, input logic [15:0] fg);
        int eff;
        eff = (len > NCH) ? NCH : len;
        for (int r = 0; r < 8; r++)
            for (int ch = 0; ch < NCH; ch++) begin
                int code, idx;
                code = int'(t[ch*8 +: 8]);
                if (ch >= eff || code < 8'h20 || code > 8'h7E) code = 8'h20;
                idx = code - 8'h20;
                for (int c = 0; c < 5; c++)
                    exp_q.push_back(font_m[r][idx*5 + 4 - c] ? fg : 16'h0000);
            end
    endtask

    task automatic run_line(input logic [NCH*8-1:0] t, input int len,
                            input logic [15:0] fg, input bit disturb);
        push_expected(t, len, fg);
        frame_pix = 0;
        @(negedge clk);
        text_chars = t; text_len = 5'(len); fg_color = fg; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        check(pix_valid == 1'b0, "R2 no pixel yet", int'(pix_valid), 0);
        @(negedge clk);
        check(pix_valid == 1'b1, "R2 first pixel valid", int'(pix_valid), 1);
        if (disturb) begin
            repeat (40) @(negedge clk);
            text_chars = pack_text("ZZZZZZZZZZZZZZZZZZZ");
            text_len = 5'd19; fg_color = 16'h1234; start = 1'b1;
            repeat (3) @(negedge clk);
            start = 1'b0;
        end
        while (exp_q.size() != 0 || busy) @(negedge clk);
        check(frame_pix == LINE_PIX, "R3 transfer count", frame_pix, LINE_PIX);
        check(!busy && !pix_valid, "R3 idle after line", int'({busy, pix_valid}), 0);
        if (disturb) begin
            @(negedge clk);
            check(!busy && !pix_valid, "R9 ignored start stays idle", int'({busy, pix_valid}), 0);
        end
    endtask

    initial begin
        logic [NCH*8-1:0] odd;
        repeat (3) @(negedge clk);
        check(!busy, "R1 busy low in reset", int'(busy), 0);
        check(!pix_valid, "R1 valid low in reset", int'(pix_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !pix_valid, "R1 idle after reset", int'({busy, pix_valid}), 0);

        for (int r = 0; r < 8; r++) load_row(r, 3);

        ready_mode = 0;
        run_line(pack_text("Hello, world!"), 13, 16'hF800, 1'b0);           // R4 R5
        ready_mode = 1;
        run_line(pack_text(" !09AZaz~{}|@#$%^&*"), 19, 16'h07E0, 1'b0);     // R8
        run_line(pack_text("hidden text"), 0, 16'hFFFF, 1'b0);              // R6 empty
        odd = pack_text("Ab~ cdefghijklmnopq");
        odd[1*8 +: 8] = 8'h00; odd[4*8 +: 8] = 8'h7F;
        odd[6*8 +: 8] = 8'h80; odd[9*8 +: 8] = 8'hFF; odd[11*8 +: 8] = 8'h1F;
        run_line(odd, 25, 16'h001F, 1'b0);                                   // R6 clamp, R7
        run_line(pack_text("busy start test"), 15, 16'hABCD, 1'b1);         // R9
        load_row(3, 11);
        load_row(7, 29);
        run_line(pack_text("Hello, world!"), 13, 16'h5A5A, 1'b0);           // R10

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule